// File: doc/BRIEF.md
# Segment-to-Descriptor Splitter

This block turns a stream of buffer segments, each an address and a byte length, into entries for a scatter-gather table. Every entry is 128 bits wide and carries one piece of a segment. No piece crosses a 64 KiB address window, so a segment that straddles a window edge, or that is longer than a window, becomes several entries. The final entry of a list carries an end-of-list flag. The block holds each entry back until it knows whether another entry follows, and only then sets the flag.

The table has a fixed capacity. A list that needs more entries than that aborts. The block then swallows the rest of the list and ends it with a zero count and an overflow flag, so the caller can move the transfer to a programmed-I/O path. A list ends at a segment flagged last, or at a segment of length zero. Each list finishes with a one-cycle done pulse that carries the entry count.

Top module: `seg_desc_splitter`

## Requirements
- R1: The size of each piece is the smaller of two values: the bytes left in the segment, and 0x10000 minus the low 16 bits of the current address. No entry therefore crosses a 64 KiB address boundary.
- R2: Consecutive pieces of one segment are contiguous. Each piece starts where the previous one ended, and together the pieces cover exactly the segment's bytes.
- R3: The length field is the piece size truncated to 16 bits, so a piece of exactly 65536 bytes is encoded with length 0.
- R4: An entry on `desc_data` is laid out as [127:96]=0, [95:64]=address, [63:32]=0, [31:0]=length word. Each 32-bit word is byte-swapped into big-endian order. The length word before swapping is {eol, 15'b0, len16}.
- R5: The eol bit (bit 31 of the unswapped length word) is 1 on the last entry of a list and 0 on every other entry.
- R6: A list needing more than MAX_ENTRIES entries reports overflow. The block releases at most MAX_ENTRIES-1 entries and never the overflowing one. It accepts the remaining segments up to and including the one that ends the list, then pulses `done` with `done_count`=0 and `done_overflow`=1. A list of exactly MAX_ENTRIES entries completes normally.
- R7: A zero-length segment ends the list and produces no entry. A list made only of a zero-length segment gives `done` with count 0 and overflow 0.
- R8: Each list produces exactly one single-cycle `done` pulse. On success it comes after the eol entry has been accepted, and `done_count` equals the number of entries released.
- R9: While `desc_valid` is high and `desc_ready` is low, `desc_valid` stays high and `desc_data` stays unchanged.
- R10: After reset, `desc_valid` and `done` are low and `seg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high with seg_valid |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes; 0 ends the list |
| seg_last | input | 1 | Segment is the last of its list |
| desc_valid | output | 1 | Entry offered |
| desc_ready | input | 1 | Entry taken when high with desc_valid |
| desc_data | output | 128 | Encoded entry |
| done | output | 1 | One-cycle list completion pulse |
| done_count | output | CNT_W | Entries in the list, 0 on overflow or empty list |
| done_overflow | output | 1 | List exceeded MAX_ENTRIES |

## Verification
The hardest case to reach is overflow in the middle of a list whose overflowing segment is not the last one. That case needs more than MAX_ENTRIES pieces, and more segments must follow that the block has to discard. The stimulus reaches it with a single segment of 65 full windows, which yields 65 pieces, followed by two further segments. A second case sits just below the limit: exactly MAX_ENTRIES pieces must finish normally. Random output stalls run alongside window-straddling segments to show that the held-back entry is released correctly and gets its eol flag only when the list has truly ended.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;
   localparam int ADDR_W   = 32;
   localparam int WIN_BITS = 16;
   localparam int ENTRY_W  = 128;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_DRAIN = 2'd1,
      ST_DONE  = 2'd2
   } split_state_e;

   function automatic logic [31:0] bswap32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction
endpackage

// File: rtl/seg_piece_cut.sv
module seg_piece_cut #(
   parameter int LEN_W = 32
) (
   input  logic [31:0]      cur_addr,
   input  logic [LEN_W-1:0] cur_rem,
   output logic [LEN_W-1:0] piece
);
   import seg_desc_pkg::*;
   localparam logic [WIN_BITS:0] WIN_SIZE = {1'b1, {WIN_BITS{1'b0}}};

   logic [WIN_BITS:0]  room;
   logic [LEN_W-1:0]   room_w;

   always_comb begin
      room   = WIN_SIZE - {1'b0, cur_addr[WIN_BITS-1:0]};
      room_w = LEN_W'(room);
      piece  = (cur_rem < room_w) ? cur_rem : room_w;
   end
endmodule

// File: rtl/seg_desc_encode.sv
module seg_desc_encode #(
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [31:0]  addr,
   input  logic [15:0]  len16,
   input  logic         eol,
   output logic [127:0] entry
);
   import seg_desc_pkg::*;
   logic [31:0] len_word;
   assign len_word = {eol, 15'd0, len16};

   generate
      if (BIG_ENDIAN) begin : g_be
         assign entry = {32'd0, bswap32(addr), 32'd0, bswap32(len_word)};
      end else begin : g_le
         assign entry = {32'd0, addr, 32'd0, len_word};
      end
   endgenerate
endmodule

// File: rtl/seg_desc_splitter.sv
module seg_desc_splitter #(
   parameter int LEN_W       = 32,
   parameter int MAX_ENTRIES = 64,
   parameter bit BIG_ENDIAN  = 1'b1,
   localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seg_valid,
   output logic             seg_ready,
   input  logic [31:0]      seg_addr,
   input  logic [LEN_W-1:0] seg_len,
   input  logic             seg_last,
   output logic             desc_valid,
   input  logic             desc_ready,
   output logic [127:0]     desc_data,
   output logic             done,
   output logic [CNT_W-1:0] done_count,
   output logic             done_overflow
);
   import seg_desc_pkg::*;

   generate
      if (LEN_W < WIN_BITS + 1) begin : g_bad_len
         $error("LEN_W must hold a full 64 KiB piece");
      end
      if (MAX_ENTRIES < 2) begin : g_bad_max
         $error("MAX_ENTRIES must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ENTRIES);

   split_state_e     state;
   logic [31:0]      cur_addr;
   logic [LEN_W-1:0] cur_rem;
   logic             cur_active;
   logic             cur_last;
   logic             fin;
   logic             hold_valid;
   logic [31:0]      hold_addr;
   logic [15:0]      hold_len;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] done_cnt_q;
   logic             done_ovf_q;

   logic [LEN_W-1:0] piece;
   logic             at_cap;
   logic             desc_fire;
   logic             seg_fire;
   logic             gen_ok;
   logic             ovf_hit;
   logic             list_close;
   logic             seg_ends;

   seg_piece_cut #(.LEN_W(LEN_W)) cut_i (
      .cur_addr (cur_addr),
      .cur_rem  (cur_rem),
      .piece    (piece)
   );

   seg_desc_encode #(.BIG_ENDIAN(BIG_ENDIAN)) enc_i (
      .addr  (hold_addr),
      .len16 (hold_len),
      .eol   (fin),
      .entry (desc_data)
   );

   always_comb begin
      at_cap     = (count == CAP);
      desc_valid = (state == ST_RUN) && hold_valid &&
                   (cur_active ? !at_cap : fin);
      seg_ready  = ((state == ST_RUN) && !cur_active && !fin) ||
                   (state == ST_DRAIN);
      desc_fire  = desc_valid && desc_ready;
      seg_fire   = seg_valid && seg_ready;
      seg_ends   = seg_last || (seg_len == '0);
      gen_ok     = (state == ST_RUN) && cur_active && !at_cap &&
                   (!hold_valid || desc_fire);
      ovf_hit    = (state == ST_RUN) && cur_active && at_cap;
      list_close = (state == ST_RUN) && fin && (!hold_valid || desc_fire);
   end

   assign done          = (state == ST_DONE);
   assign done_count    = done_cnt_q;
   assign done_overflow = done_ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_RUN;
         cur_addr   <= '0;
         cur_rem    <= '0;
         cur_active <= 1'b0;
         cur_last   <= 1'b0;
         fin        <= 1'b0;
         hold_valid <= 1'b0;
         hold_addr  <= '0;
         hold_len   <= '0;
         count      <= '0;
         done_cnt_q <= '0;
         done_ovf_q <= 1'b0;
      end else begin
         unique case (state)
            ST_RUN: begin
               if (seg_fire) begin
                  if (seg_len == '0) begin
                     fin <= 1'b1;
                  end else begin
                     cur_addr   <= seg_addr;
                     cur_rem    <= seg_len;
                     cur_active <= 1'b1;
                     cur_last   <= seg_last;
                  end
               end
               if (gen_ok) begin
                  hold_valid <= 1'b1;
                  hold_addr  <= cur_addr;
                  hold_len   <= piece[15:0];
                  count      <= count + CNT_W'(1);
                  cur_addr   <= cur_addr + 32'(piece);
                  cur_rem    <= cur_rem - piece;
                  if (cur_rem == piece) begin
                     cur_active <= 1'b0;
                     if (cur_last) fin <= 1'b1;
                  end
               end
               if (ovf_hit) begin
                  hold_valid <= 1'b0;
                  cur_active <= 1'b0;
                  done_cnt_q <= '0;
                  done_ovf_q <= 1'b1;
                  state      <= cur_last ? ST_DONE : ST_DRAIN;
               end
               if (list_close) begin
                  hold_valid <= 1'b0;
                  done_cnt_q <= count;
                  done_ovf_q <= 1'b0;
                  state      <= ST_DONE;
               end
            end
            ST_DRAIN: begin
               if (seg_fire && seg_ends) state <= ST_DONE;
            end
            ST_DONE: begin
               state      <= ST_RUN;
               count      <= '0;
               fin        <= 1'b0;
               cur_active <= 1'b0;
               cur_last   <= 1'b0;
               hold_valid <= 1'b0;
            end
            default: state <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/seg_desc_splitter_chk.sv
module seg_desc_splitter_chk #(
   parameter int LEN_W       = 32,
   parameter int MAX_ENTRIES = 64,
   parameter bit BIG_ENDIAN  = 1'b1,
   localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             seg_valid,
   input logic             seg_ready,
   input logic             desc_valid,
   input logic             desc_ready,
   input logic [127:0]     desc_data,
   input logic             done,
   input logic [CNT_W-1:0] done_count,
   input logic             done_overflow
);
   import seg_desc_pkg::*;

   logic [31:0] addr_w;
   logic [31:0] len_w;
   logic [16:0] span;

   always_comb begin
      addr_w = BIG_ENDIAN ? bswap32(desc_data[95:64]) : desc_data[95:64];
      len_w  = BIG_ENDIAN ? bswap32(desc_data[31:0])  : desc_data[31:0];
      span   = {1'b0, addr_w[15:0]} +
               ((len_w[15:0] == 16'd0) ? 17'h10000 : {1'b0, len_w[15:0]});
   end

   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !desc_ready |=> desc_valid && $stable(desc_data));

   a_r1_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> span <= 17'h10000);

   a_r4_zero_words: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> (desc_data[127:96] == 32'd0) && (desc_data[63:32] == 32'd0));

   a_r6_ovf_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_overflow |-> done_count == '0);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !desc_valid && !seg_ready);
endmodule

bind seg_desc_splitter seg_desc_splitter_chk #(
   .LEN_W(LEN_W), .MAX_ENTRIES(MAX_ENTRIES), .BIG_ENDIAN(BIG_ENDIAN)
) chk_i (
   .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
   .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
   .done(done), .done_count(done_count), .done_overflow(done_overflow)
);

// File: tb/seg_desc_splitter_tb_top.sv
module seg_desc_splitter_tb_top;
   import seg_desc_pkg::*;
   localparam int MAXE  = 64;
   localparam int CNT_W = $clog2(MAXE + 1);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n;
   logic             seg_valid;
   logic             seg_ready;
   logic [31:0]      seg_addr;
   logic [31:0]      seg_len;
   logic             seg_last;
   logic             desc_valid;
   logic             desc_ready;
   logic [127:0]     desc_data;
   logic             done;
   logic [CNT_W-1:0] done_count;
   logic             done_overflow;

   seg_desc_splitter #(.LEN_W(32), .MAX_ENTRIES(MAXE), .BIG_ENDIAN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
      .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
      .done(done), .done_count(done_count), .done_overflow(done_overflow)
   );

   int n_chk  = 0;
   int n_fail = 0;

   logic [31:0]  s_addr [8];
   logic [31:0]  s_len  [8];
   logic         s_last [8];
   int           s_n;
   logic [127:0] exp_q[$];
   int           exp_cnt;
   bit           exp_ovf;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [127:0] mk(input logic [31:0] a, input logic [15:0] l,
                                       input logic e);
      return {32'd0, bswap32(a), 32'd0, bswap32({e, 15'd0, l})};
   endfunction

   task automatic build_expected();
      logic [31:0] a_q[$];
      logic [15:0] l_q[$];
      int tot = 0;
      exp_q.delete();
      for (int i = 0; i < s_n; i++) begin
         logic [31:0] a = s_addr[i];
         longint r = s_len[i];
         if (r == 0) break;
         while (r > 0) begin
            longint room = 65536 - a[15:0];
            longint p = (r < room) ? r : room;
            a_q.push_back(a);
            l_q.push_back(16'(p));
            a = a + 32'(p);
            r = r - p;
            tot++;
         end
         if (s_last[i]) break;
      end
      exp_ovf = (tot > MAXE);
      if (exp_ovf) begin
         for (int k = 0; k < MAXE - 1; k++) exp_q.push_back(mk(a_q[k], l_q[k], 1'b0));
         exp_cnt = 0;
      end else begin
         for (int k = 0; k < tot; k++) exp_q.push_back(mk(a_q[k], l_q[k], k == tot - 1));
         exp_cnt = tot;
      end
   endtask

   task automatic run_list(input string name, input bit bp);
      int idx = 0;
      int got = 0;
      int cyc = 0;
      bit seen = 0;
      bit stall_prev = 0;
      logic [127:0] stall_data = '0;
      build_expected();
      while (!seen && cyc < 5000) begin
         bit in_fire;
         @(negedge clk);
         cyc++;
         seg_valid  = (idx < s_n);
         seg_addr   = (idx < s_n) ? s_addr[idx] : 32'd0;
         seg_len    = (idx < s_n) ? s_len[idx]  : 32'd0;
         seg_last   = (idx < s_n) ? s_last[idx] : 1'b0;
         desc_ready = bp ? (($urandom % 3) != 0) : 1'b1;
         #1;
         in_fire = seg_valid && seg_ready;
         if (stall_prev) begin
            check(desc_valid && desc_data == stall_data, "R9",
                  {name, " stalled entry held"}, desc_data, stall_data);
         end
         stall_prev = desc_valid && !desc_ready;
         stall_data = desc_data;
         if (desc_valid && desc_ready) begin
            if (got < exp_q.size())
               check(desc_data == exp_q[got], "R1/R2/R3/R4/R5",
                     {name, " entry"}, desc_data, exp_q[got]);
            else
               check(1'b0, "R6", {name, " extra entry"}, desc_data, '0);
            got++;
         end
         if (done) begin
            seen = 1;
            check(done_count == CNT_W'(exp_cnt), "R8", {name, " done_count"},
                  128'(done_count), 128'(exp_cnt));
            check(done_overflow == exp_ovf, "R6", {name, " done_overflow"},
                  128'(done_overflow), 128'(exp_ovf));
            check(got == exp_q.size(), "R8", {name, " entries released"},
                  128'(got), 128'(exp_q.size()));
            check(idx == s_n, "R6", {name, " segments consumed"},
                  128'(idx), 128'(s_n));
         end
         if (in_fire) idx++;
      end
      if (!seen) check(1'b0, "R8", {name, " done never seen"}, 128'(cyc), 128'(0));
      @(negedge clk);
      seg_valid = 1'b0;
      #1;
      check(!done, "R8", {name, " done is one cycle"}, 128'(done), 128'(0));
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      seg_valid = 1'b0; seg_addr = '0; seg_len = '0; seg_last = 1'b0;
      desc_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: reset state
      check(!desc_valid, "R10", "desc_valid after reset", 128'(desc_valid), 0);
      check(!done, "R10", "done after reset", 128'(done), 0);
      check(seg_ready, "R10", "seg_ready after reset", 128'(seg_ready), 1);

      // R1: small aligned segment
      s_n = 1; s_addr[0] = 32'h1000_0000; s_len[0] = 32'h200; s_last[0] = 1;
      run_list("small", 0);

      // R1 R2: straddles a window edge
      s_n = 1; s_addr[0] = 32'h0001_FF00; s_len[0] = 32'h300; s_last[0] = 1;
      run_list("straddle", 1);

      // R3: exact 64 KiB piece encodes as 0
      s_n = 1; s_addr[0] = 32'h0002_0000; s_len[0] = 32'h1_0000; s_last[0] = 1;
      run_list("full_window", 0);

      // R2 R5: multi-segment list with backpressure
      s_n = 3;
      s_addr[0] = 32'h0003_8000; s_len[0] = 32'h2_0000; s_last[0] = 0;
      s_addr[1] = 32'h0040_FFFF; s_len[1] = 32'h2;      s_last[1] = 0;
      s_addr[2] = 32'h0100_0010; s_len[2] = 32'h40;     s_last[2] = 1;
      run_list("multi", 1);

      // R7: zero-length segment ends the list
      s_n = 2;
      s_addr[0] = 32'h0005_F000; s_len[0] = 32'h2000; s_last[0] = 0;
      s_addr[1] = 32'h0;         s_len[1] = 32'h0;    s_last[1] = 0;
      run_list("zero_term", 1);

      // R7: empty list
      s_n = 1; s_addr[0] = 32'h0; s_len[0] = 32'h0; s_last[0] = 1;
      run_list("empty", 0);

      // R6: overflow mid-list, remaining segments drained
      s_n = 3;
      s_addr[0] = 32'h0; s_len[0] = 32'd65 * 32'h1_0000; s_last[0] = 0;
      s_addr[1] = 32'h0100_0000; s_len[1] = 32'h10; s_last[1] = 0;
      s_addr[2] = 32'h0200_0000; s_len[2] = 32'h10; s_last[2] = 1;
      run_list("overflow", 1);

      // R6: exactly MAX_ENTRIES entries completes
      s_n = 1; s_addr[0] = 32'h1000_0000; s_len[0] = 32'd64 * 32'h1_0000; s_last[0] = 1;
      run_list("at_capacity", 1);

      // R6: overflow on the last segment
      s_n = 1; s_addr[0] = 32'h0000_8000; s_len[0] = 32'd64 * 32'h1_0000; s_last[0] = 1;
      run_list("overflow_last", 0);

      // R8: recovery after overflow
      s_n = 2;
      s_addr[0] = 32'h0007_FFF0; s_len[0] = 32'h20; s_last[0] = 0;
      s_addr[1] = 32'h0009_0000; s_len[1] = 32'h8;  s_last[1] = 1;
      run_list("recover", 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule